// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block sits beside the fetch stage of a core that issues one instruction word per cycle. It runs two kinds of hardware loop, and neither needs a branch instruction. A single-instruction repeat issues the word after the setup instruction again and again. A block loop sends the program counter back to the top of an address range each time the last word of the range is issued. Each loop type has its own counter and its own active flag.

The fetch stage gives the block the address of the word it is issuing in this cycle. It also gives setup strobes, decoded from the repeat and block-loop setup instructions, with a count and an end address. The block answers with a hold request, which tells fetch to issue the same word again. It also gives a redirect flag and a redirect address for the next fetch. A stall input freezes the block for the stalled cycle. Nested loops beyond one level of each kind, and interrupts, are not handled.

Top module: `hwloop_seq`

## Requirements
- R1: After reset, both active flags, the hold request and the redirect flag are all low.
- R2: A repeat setup with count N, taken in a cycle that is not stalled, makes the next instruction word issue N+1 times in total. `hold_fetch_o` is high on each of the first N of those issues.
- R3: `rpt_active_o` is high from the cycle after a repeat setup with N>0 until the last repeated issue has completed. The repeat counter drops by one on every cycle that is not stalled during this time.
- R4: A block-loop setup taken at address A with end address E sets `do_active_o`. When the word at E is issued and the loop counter is non-zero, `npc_ovr_o` is high and `npc_o` equals A+2, the word after the setup. Addresses step by 2 per instruction word.
- R5: A block loop set up with count M runs its body M+1 times. The loop counter drops by one on each redirect that is not stalled.
- R6: When the word at E is issued with the loop counter at zero, there is no redirect. `do_active_o` falls at that clock edge, and fetch continues at E+2.
- R7: While a repeat is active, the block loop does not redirect. A repeated word sitting at E redirects only on its final issue.
- R8: In a cycle where `stall_i` is high, no counter, address register or active flag changes.
- R9: A repeat setup with count 0 gives no hold and leaves `rpt_active_o` low. The next word issues once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_i | input | PC_W | Address of the word issued this cycle |
| stall_i | input | 1 | Freeze all loop state this cycle |
| rpt_set_i | input | 1 | Repeat setup instruction issued this cycle |
| rpt_cnt_i | input | CNT_W | Further issues of the repeated word |
| do_set_i | input | 1 | Block-loop setup instruction issued this cycle |
| do_cnt_i | input | CNT_W | Further passes over the loop body |
| do_end_i | input | PC_W | Address of the last word of the loop body |
| npc_ovr_o | output | 1 | Next fetch comes from npc_o |
| npc_o | output | PC_W | Loop body start address |
| hold_fetch_o | output | 1 | Issue the same word again next cycle |
| rpt_active_o | output | 1 | Repeat in progress |
| do_active_o | output | 1 | Block loop in progress |

## Verification
The assertions assume that the fetch stage obeys hold and redirect. They also assume that a setup strobe never arrives while a loop of the same kind is already active, and that the end address is even and lies after the setup address. The stimulus meets these assumptions by driving `pc_i` from a fetch model in the bench. That model follows the expected hold and redirect values. The bench raises each setup strobe only when the fetch model reaches the chosen setup address, and it places every loop body ahead of its end address.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  // Every instruction word takes two address units.
  localparam int unsigned WORD_STEP = 2;

  function automatic logic [23:0] next_word(input logic [23:0] a);
    return a + 24'(WORD_STEP);
  endfunction

  // Counter step shared by both loop kinds; it saturates at zero.
  function automatic logic [15:0] count_step(input logic [15:0] c);
    return (c == 16'd0) ? 16'd0 : c - 16'd1;
  endfunction
endpackage

// File: rtl/hwloop_rpt.sv
module hwloop_rpt #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic             set_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             active_o,
  output logic [CNT_W-1:0] count_o
);
  import hwloop_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;
  logic             last_issue;
  logic [15:0]      stepped;

  assign stepped    = count_step(16'(cnt_q));
  assign last_issue = act_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!stall_i) begin
      if (set_i) begin
        cnt_q <= cnt_i;
        act_q <= (cnt_i != '0);
      end else if (act_q) begin
        cnt_q <= stepped[CNT_W-1:0];
        act_q <= !last_issue;
      end
    end
  end

  assign active_o = act_q;
  assign count_o  = cnt_q;
endmodule

// File: rtl/hwloop_do.sv
module hwloop_do #(
  parameter int PC_W  = 24,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic             set_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [PC_W-1:0]  end_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             rpt_busy_i,
  output logic             active_o,
  output logic             wrap_o,
  output logic             exit_o,
  output logic [PC_W-1:0]  start_o,
  output logic [CNT_W-1:0] count_o,
  output logic [PC_W-1:0]  end_o
);
  import hwloop_pkg::*;

  logic [PC_W-1:0]  start_q, end_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;
  logic             at_end;
  logic [15:0]      stepped;
  logic [23:0]      after_setup;

  assign after_setup = next_word(24'(pc_i));
  assign stepped     = count_step(16'(cnt_q));
  assign at_end      = act_q && !rpt_busy_i && (pc_i == end_q);
  assign wrap_o      = at_end && (cnt_q != '0);
  assign exit_o      = at_end && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
    end else if (!stall_i) begin
      if (set_i) begin
        start_q <= after_setup[PC_W-1:0];
        end_q   <= end_i;
        cnt_q   <= cnt_i;
        act_q   <= 1'b1;
      end else if (wrap_o) begin
        cnt_q <= stepped[CNT_W-1:0];
      end else if (exit_o) begin
        act_q <= 1'b0;
      end
    end
  end

  assign active_o = act_q;
  assign start_o  = start_q;
  assign count_o  = cnt_q;
  assign end_o    = end_q;
endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq #(
  parameter int PC_W  = 24,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             stall_i,
  input  logic             rpt_set_i,
  input  logic [CNT_W-1:0] rpt_cnt_i,
  input  logic             do_set_i,
  input  logic [CNT_W-1:0] do_cnt_i,
  input  logic [PC_W-1:0]  do_end_i,
  output logic             npc_ovr_o,
  output logic [PC_W-1:0]  npc_o,
  output logic             hold_fetch_o,
  output logic             rpt_active_o,
  output logic             do_active_o
);
  logic             rpt_busy;
  logic [CNT_W-1:0] rpt_count;
  logic             do_busy, do_wrap, do_exit;
  logic [PC_W-1:0]  do_start, do_end;
  logic [CNT_W-1:0] do_count;

  hwloop_rpt #(.CNT_W(CNT_W)) u_rpt (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
    .set_i(rpt_set_i), .cnt_i(rpt_cnt_i),
    .active_o(rpt_busy), .count_o(rpt_count)
  );

  hwloop_do #(.PC_W(PC_W), .CNT_W(CNT_W)) u_do (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
    .set_i(do_set_i), .cnt_i(do_cnt_i), .end_i(do_end_i),
    .pc_i(pc_i), .rpt_busy_i(rpt_busy),
    .active_o(do_busy), .wrap_o(do_wrap), .exit_o(do_exit),
    .start_o(do_start), .count_o(do_count), .end_o(do_end)
  );

  assign hold_fetch_o = rpt_busy;
  assign npc_ovr_o    = do_wrap;
  assign npc_o        = do_start;
  assign rpt_active_o = rpt_busy;
  assign do_active_o  = do_busy;
endmodule

// File: rtl/hwloop_chk.sv
module hwloop_chk #(
  parameter int PC_W  = 24,
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall_i,
  input logic             rpt_set_i,
  input logic [CNT_W-1:0] rpt_cnt_i,
  input logic             do_set_i,
  input logic [PC_W-1:0]  pc_i,
  input logic             npc_ovr_o,
  input logic             rpt_active_o,
  input logic             do_active_o,
  input logic [CNT_W-1:0] rpt_count,
  input logic [CNT_W-1:0] do_count,
  input logic [PC_W-1:0]  do_end
);
  p_stall_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(rpt_active_o) && $stable(do_active_o)
                 && $stable(rpt_count) && $stable(do_count)));

  p_rpt_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_active_o && !stall_i && !rpt_set_i) |=> (rpt_count == $past(rpt_count) - 1'b1));

  p_rpt_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_set_i && !stall_i && rpt_cnt_i == '0) |=> !rpt_active_o);

  p_rpt_blocks_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_active_o |-> !npc_ovr_o);

  p_wrap_decrements_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (npc_ovr_o && !stall_i && !do_set_i) |=> (do_count == $past(do_count) - 1'b1));

  p_loop_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_active_o && !rpt_active_o && !stall_i && !do_set_i
     && pc_i == do_end && do_count == '0) |=> !do_active_o);

  p_wrap_needs_loop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    npc_ovr_o |-> do_active_o);
endmodule

bind hwloop_seq hwloop_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .rpt_set_i(rpt_set_i),
  .rpt_cnt_i(rpt_cnt_i), .do_set_i(do_set_i), .pc_i(pc_i),
  .npc_ovr_o(npc_ovr_o), .rpt_active_o(rpt_active_o), .do_active_o(do_active_o),
  .rpt_count(rpt_count), .do_count(do_count), .do_end(do_end)
);

// File: tb/hwloop_seq_tb.sv
module hwloop_seq_tb;
  localparam int PC_W = 24;
  localparam int CNT_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] pc_i = '0;
  logic stall_i = 1'b0;
  logic rpt_set_i = 1'b0;
  logic [CNT_W-1:0] rpt_cnt_i = '0;
  logic do_set_i = 1'b0;
  logic [CNT_W-1:0] do_cnt_i = '0;
  logic [PC_W-1:0] do_end_i = '0;
  logic npc_ovr_o, hold_fetch_o, rpt_active_o, do_active_o;
  logic [PC_W-1:0] npc_o;

  always #2.5 clk = ~clk;

  hwloop_seq #(.PC_W(PC_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .stall_i(stall_i),
    .rpt_set_i(rpt_set_i), .rpt_cnt_i(rpt_cnt_i), .do_set_i(do_set_i),
    .do_cnt_i(do_cnt_i), .do_end_i(do_end_i), .npc_ovr_o(npc_ovr_o),
    .npc_o(npc_o), .hold_fetch_o(hold_fetch_o), .rpt_active_o(rpt_active_o),
    .do_active_o(do_active_o)
  );

  int checks = 0, errors = 0;
  // reference state
  bit m_ra = 0, m_da = 0;
  int m_rc = 0, m_dc = 0, m_start = 0, m_end = 0;
  int pc = 0;
  int hits[int];
  // setup plan: address that carries each setup instruction (-1: none)
  int rpt_at = -1, rpt_n = 0, do_at = -1, do_n = 0, do_e = 0;
  int stall_cycles[int];
  int cyc_no = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d pc %0h)", tag, act, exp, cyc_no, pc);
    end
  endtask

  // one issue cycle: drive at negedge, compare, advance model at posedge
  task automatic step();
    bit rs, ds, st, e_hold, e_ovr, at_end;
    rs = (pc == rpt_at);
    ds = (pc == do_at);
    st = stall_cycles.exists(cyc_no);
    pc_i = PC_W'(pc); stall_i = st;
    rpt_set_i = rs; rpt_cnt_i = CNT_W'(rpt_n);
    do_set_i = ds; do_cnt_i = CNT_W'(do_n); do_end_i = PC_W'(do_e);
    #1;
    e_hold = m_ra;
    at_end = m_da && !m_ra && (pc == m_end);
    e_ovr = at_end && (m_dc != 0);
    chk("R2 hold", int'(hold_fetch_o), int'(e_hold));
    chk("R3 rpt_active", int'(rpt_active_o), int'(m_ra));
    chk("R4 redirect", int'(npc_ovr_o), int'(e_ovr));
    if (e_ovr) chk("R4 target", int'(npc_o), m_start);
    chk("R6 do_active", int'(do_active_o), int'(m_da));
    @(posedge clk);
    if (!st) begin
      if (hits.exists(pc)) hits[pc]++; else hits[pc] = 1;
      if (rs) begin m_rc = rpt_n; m_ra = (rpt_n != 0); end
      else if (m_ra) begin m_rc--; m_ra = (m_rc != 0); end
      if (ds) begin m_start = pc + 2; m_end = do_e; m_dc = do_n; m_da = 1; end
      else if (at_end) begin
        if (m_dc != 0) m_dc--; else m_da = 0;
      end
      if (e_ovr) pc = m_start;
      else if (!e_hold) pc = pc + 2;
    end
    cyc_no++;
    @(negedge clk);
  endtask

  task automatic run_to(int target, int limit);
    for (int i = 0; i < limit && pc != target; i++) step();
    chk("R5 reached exit address", pc, target);
  endtask

  task automatic restart(int at);
    hits.delete(); stall_cycles.delete();
    rpt_at = -1; do_at = -1; pc = at;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset hold", int'(hold_fetch_o), 0);
    chk("R1 reset redirect", int'(npc_ovr_o), 0);
    chk("R1 reset rpt_active", int'(rpt_active_o), 0);
    chk("R1 reset do_active", int'(do_active_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: repeat 2 at 0x100 -> word 0x102 issues three times
    restart('h100); rpt_at = 'h100; rpt_n = 2;
    run_to('h106, 20);
    chk("R2 repeat issues", hits['h102], 3);
    chk("R2 setup issues", hits['h100], 1);

    // R9: repeat 0 -> next word once, no hold
    restart('h140); rpt_at = 'h140; rpt_n = 0;
    run_to('h146, 10);
    chk("R9 zero repeat issues", hits['h142], 1);

    // R2: divide-style 18 issues, with stalls inside (R8)
    restart('h180); rpt_at = 'h180; rpt_n = 17;
    stall_cycles[cyc_no + 4] = 1; stall_cycles[cyc_no + 5] = 1;
    run_to('h186, 40);
    chk("R8 stalled repeat issues", hits['h182], 18);

    // R4/R5/R6: block loop count 2 over 0x202..0x206
    restart('h200); do_at = 'h200; do_n = 2; do_e = 'h206;
    run_to('h208, 40);
    chk("R5 body passes", hits['h202], 3);
    chk("R5 end passes", hits['h206], 3);
    chk("R6 loop ended", int'(do_active_o), 0);

    // R6: count 0 -> body once
    restart('h240); do_at = 'h240; do_n = 0; do_e = 'h244;
    run_to('h246, 20);
    chk("R6 single pass", hits['h242], 1);

    // R8: stall on the end word during a block loop
    restart('h280); do_at = 'h280; do_n = 1; do_e = 'h284;
    stall_cycles[cyc_no + 2] = 1; stall_cycles[cyc_no + 5] = 1;
    stall_cycles[cyc_no + 6] = 1;
    run_to('h286, 40);
    chk("R8 stalled loop passes", hits['h282], 2);

    // R7: repeated word at the end address redirects only on final issue
    restart('h300); do_at = 'h300; do_n = 1; do_e = 'h306;
    rpt_at = 'h304; rpt_n = 2;
    run_to('h308, 60);
    chk("R7 end word issues", hits['h306], 6);
    chk("R7 repeat setup issues", hits['h304], 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule